// File: doc/BRIEF.md
# Flash Fetch Wait-State Controller

This block sits between a processor's fetch and read port and a slow non-volatile memory array. A single 32-bit control word sets the read mode: how many wait states each array access takes, and whether speculative prefetches of conditional-branch targets are held back. The same word holds the policy for an attached instruction cache and the bus-priority choice for the interconnect.

The requester raises `req_i` and keeps its inputs steady until `ready_o` is high. An access served from the array holds `ready_o` low for the configured number of wait states. A cache hit that the policy allows completes in the request cycle. The cache policy depends on three things: the address region of the access, whether the processor is in interrupt context, and whether the access is a vector fetch. A program or erase event raises an invalidate pulse unless automatic invalidation has been turned off.

Top module: `flash_ws_ctrl`

## Requirements
- R1: After reset the control word reads 0x00000001. This is mode 1, one wait state, with every cache bit and the bus-priority field at 0.
- R2: The mode field (bits 2:0) sets the wait count. Modes 0 and 2 give 0 wait states, modes 1 and 3 give 1, and modes 4, 5, 6 and 7 give 2.
- R3: An access not served by the cache holds `ready_o` low for exactly N cycles, N being the wait count, and raises it in cycle N+1 with `rdata_o` equal to `mem_rdata_i`.
- R4: A fetch that the policy allows to use the cache and that has `cache_hit_i` high completes in the request cycle with `rdata_o` equal to `cache_rdata_i`. `perf_cnt_o` is high in that cycle.
- R5: Modes 2, 3, 5, 6 and 7 turn on prefetch suppression. While suppression is on, `pf_hold_o` is high exactly when `cond_br_pf_i` is high and `br_in_exec_i` is low. In all other modes `pf_hold_o` stays low.
- R6: `cache_lookup_o` is high for a fetch request under these conditions. For region 0 (internal flash), bit 3 must be 0. For region 1 (external bus), bit 6 must be 0. For region 2 (RAM code space), bit 7 must be 1. Region 3 and data reads never look up.
- R7: If bit 5 is set, a fetch made in interrupt context or a vector fetch still looks up the cache. In that case `cache_use_o` and `perf_cnt_o` stay low and a hit is ignored, so the access takes the full wait count.
- R8: A write or page-erase event raises `cache_invalidate_o` in the next cycle for one cycle, unless bit 4 is set. If bit 4 is set, it stays low.
- R9: Bits 31:18 and 15:8 of the control word read as zero whatever was written to them.
- R10: `bus_prio_o` follows bits 17:16 of the control word: 0 CPU, 1 DMA, 2 DMA except channel 1, 3 none.
- R11: A mode write made during a stalled access does not change that access's wait count. It applies from the next access on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 32 | Control word write data |
| cfg_rdata_o | output | 32 | Control word read value |
| req_i | input | 1 | Access request, held until ready |
| fetch_i | input | 1 | Access is an instruction fetch |
| region_i | input | 2 | Region: 0 flash, 1 external bus, 2 RAM code, 3 other |
| irq_ctx_i | input | 1 | Processor in interrupt context |
| vec_fetch_i | input | 1 | Access is a vector fetch |
| cache_hit_i | input | 1 | Cache reports a hit |
| cache_rdata_i | input | DATA_W | Data from cache |
| mem_rdata_i | input | DATA_W | Data from array |
| ready_o | output | 1 | Access completes this cycle |
| rdata_o | output | DATA_W | Read data, zero when not ready |
| cond_br_pf_i | input | 1 | Conditional-branch target prefetch pending |
| br_in_exec_i | input | 1 | That branch has reached execute |
| pf_hold_o | output | 1 | Hold the branch-target prefetch |
| wr_evt_i | input | 1 | Array write event |
| erase_evt_i | input | 1 | Page erase event |
| cache_lookup_o | output | 1 | Cache lookup enabled for this fetch |
| cache_use_o | output | 1 | Cache may fill or serve this fetch |
| cache_invalidate_o | output | 1 | Invalidate whole cache |
| perf_cnt_o | output | 1 | Count a completed cacheable fetch |
| bus_prio_o | output | 2 | Low-latency master select |

## Verification
The control word, `bus_prio_o` and the mode decode change on the first clock edge after the write strobe, so they are checked half a cycle after that edge. The invalidate pulse appears one edge after the event and clears one edge later, and it is sampled at both points. `ready_o`, `rdata_o`, `cache_lookup_o`, `cache_use_o`, `pf_hold_o` and `perf_cnt_o` are combinational from held inputs and state. The bench drives these inputs on the falling edge and samples just after it. It counts the low-ready cycles until completion and compares that count with the wait count expected for the mode latched when the access started.

// File: rtl/flash_ws_pkg.sv
package flash_ws_pkg;
  localparam int CFG_W = 32;

  typedef enum logic [1:0] {
    RGN_FLASH = 2'd0,
    RGN_EXT   = 2'd1,
    RGN_RAM   = 2'd2,
    RGN_OTHER = 2'd3
  } region_e;

  typedef struct packed {
    logic [1:0] bus_prio;
    logic       ram_cen;
    logic       ext_cdis;
    logic       irq_cdis;
    logic       auto_inv_dis;
    logic       flash_cdis;
    logic [2:0] mode;
  } cfg_t;

  localparam logic [2:0] MODE_RESET = 3'd1;
endpackage

// File: rtl/ws_cfg_reg.sv
module ws_cfg_reg
  import flash_ws_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output cfg_t             cfg_o,
  output logic [CFG_W-1:0] rdata_o
);
  cfg_t cfg_q;
  logic unused_rsvd;
  assign unused_rsvd = ^{wdata_i[31:18], wdata_i[15:8]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= '0;
      cfg_q.mode <= MODE_RESET;
    end else if (we_i) begin
      cfg_q <= {wdata_i[17:16], wdata_i[7:0]};
    end
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = {14'd0, cfg_q.bus_prio, 8'd0, cfg_q[7:0]};

  a_r9_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (rdata_o[31:18] == '0) && (rdata_o[15:8] == '0));
endmodule

// File: rtl/ws_mode_dec.sv
module ws_mode_dec #(
  parameter int WS_W = 2
) (
  input  logic [2:0]      mode_i,
  output logic [WS_W-1:0] ws_o,
  output logic            supp_o
);
  always_comb begin
    unique case (mode_i)
      3'd0: begin ws_o = WS_W'(0); supp_o = 1'b0; end
      3'd1: begin ws_o = WS_W'(1); supp_o = 1'b0; end
      3'd2: begin ws_o = WS_W'(0); supp_o = 1'b1; end
      3'd3: begin ws_o = WS_W'(1); supp_o = 1'b1; end
      3'd4: begin ws_o = WS_W'(2); supp_o = 1'b0; end
      default: begin ws_o = WS_W'(2); supp_o = 1'b1; end // 5, and 6/7 fall to safest
    endcase
  end

  always_comb begin
    a_r2_ws_bound: assert (ws_o <= WS_W'(2));
  end
endmodule

// File: rtl/ws_stall_fsm.sv
module ws_stall_fsm #(
  parameter int WS_W   = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              fast_i,
  input  logic [WS_W-1:0]   ws_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [DATA_W-1:0] fast_rdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic            busy_q;
  logic [WS_W-1:0] cnt_q;
  logic            zero_wait;

  assign zero_wait = fast_i | (ws_i == '0);

  // wait count latched at start; later mode writes cannot stretch this access
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (req_i && !zero_wait) begin
        busy_q <= 1'b1;
        cnt_q  <= ws_i - WS_W'(1);
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - WS_W'(1);
    end
  end

  assign ready_o = busy_q ? (cnt_q == '0) : (req_i & zero_wait);
  assign rdata_o = !ready_o ? '0 : ((!busy_q && fast_i) ? fast_rdata_i : mem_rdata_i);

  a_r3_start_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(req_i) && !$past(ready_o));
  a_r11_count_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && (cnt_q != '0) |=> busy_q && (cnt_q == $past(cnt_q) - WS_W'(1)));
  a_r3_release_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && ready_o |=> !busy_q);
endmodule

// File: rtl/ws_cache_policy.sv
module ws_cache_policy
  import flash_ws_pkg::*;
(
  input  cfg_t       cfg_i,
  input  logic       req_i,
  input  logic       fetch_i,
  input  logic [1:0] region_i,
  input  logic       irq_ctx_i,
  input  logic       vec_fetch_i,
  output logic       lookup_o,
  output logic       use_o
);
  localparam int N_RGN = 4;
  logic [N_RGN-1:0] rgn_en;

  for (genvar g = 0; g < N_RGN; g++) begin : g_rgn
    if (g == int'(RGN_FLASH))     begin : g_fl assign rgn_en[g] = ~cfg_i.flash_cdis; end
    else if (g == int'(RGN_EXT))  begin : g_ex assign rgn_en[g] = ~cfg_i.ext_cdis;   end
    else if (g == int'(RGN_RAM))  begin : g_rm assign rgn_en[g] = cfg_i.ram_cen;     end
    else                          begin : g_ot assign rgn_en[g] = 1'b0;              end
  end

  assign lookup_o = req_i & fetch_i & rgn_en[region_i];
  assign use_o    = lookup_o & ~(cfg_i.irq_cdis & (irq_ctx_i | vec_fetch_i));
endmodule

// File: rtl/flash_ws_ctrl.sv
module flash_ws_ctrl
  import flash_ws_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WS_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic              req_i,
  input  logic              fetch_i,
  input  logic [1:0]        region_i,
  input  logic              irq_ctx_i,
  input  logic              vec_fetch_i,
  input  logic              cache_hit_i,
  input  logic [DATA_W-1:0] cache_rdata_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              cond_br_pf_i,
  input  logic              br_in_exec_i,
  output logic              pf_hold_o,
  input  logic              wr_evt_i,
  input  logic              erase_evt_i,
  output logic              cache_lookup_o,
  output logic              cache_use_o,
  output logic              cache_invalidate_o,
  output logic              perf_cnt_o,
  output logic [1:0]        bus_prio_o
);
  cfg_t            cfg;
  logic [WS_W-1:0] ws;
  logic            supp;
  logic            inval_q;

  ws_cfg_reg i_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .wdata_i(cfg_wdata_i),
    .cfg_o(cfg), .rdata_o(cfg_rdata_o)
  );

  ws_mode_dec #(.WS_W(WS_W)) i_dec (.mode_i(cfg.mode), .ws_o(ws), .supp_o(supp));

  ws_cache_policy i_pol (
    .cfg_i(cfg), .req_i, .fetch_i, .region_i, .irq_ctx_i, .vec_fetch_i,
    .lookup_o(cache_lookup_o), .use_o(cache_use_o)
  );

  ws_stall_fsm #(.WS_W(WS_W), .DATA_W(DATA_W)) i_fsm (
    .clk_i, .rst_ni, .req_i,
    .fast_i(cache_use_o & cache_hit_i),
    .ws_i(ws), .mem_rdata_i, .fast_rdata_i(cache_rdata_i),
    .ready_o, .rdata_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inval_q <= 1'b0;
    else         inval_q <= (wr_evt_i | erase_evt_i) & ~cfg.auto_inv_dis;
  end

  assign cache_invalidate_o = inval_q;
  assign pf_hold_o          = supp & cond_br_pf_i & ~br_in_exec_i;
  assign perf_cnt_o         = ready_o & cache_use_o;
  assign bus_prio_o         = cfg.bus_prio;

  a_r8_inval_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_invalidate_o |-> $past(wr_evt_i | erase_evt_i));
  a_r5_hold_needs_branch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_hold_o |-> cond_br_pf_i && !br_in_exec_i);
  a_r7_use_needs_lookup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_use_o |-> cache_lookup_o && !(cfg_rdata_o[5] && (irq_ctx_i || vec_fetch_i)));
endmodule

// File: tb/test_flash_ws_ctrl.sv
module test_flash_ws_ctrl;
  localparam int DW = 32;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic req = 0, fetch = 0, irq = 0, vec = 0, hit = 0;
  logic [1:0] region = 0;
  logic [DW-1:0] cache_rd = 0, mem_rd = 0, rdata;
  logic ready, cbr = 0, bexec = 0, pf_hold, wr_evt = 0, er_evt = 0;
  logic lookup, use_c, inval, perf;
  logic [1:0] bus_prio;
  int errors = 0, checks = 0;
  logic [31:0] cur_cfg = 32'h1;

  always #10 clk = ~clk;

  flash_ws_ctrl #(.DATA_W(DW)) i_flash_ws_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .req_i(req), .fetch_i(fetch), .region_i(region),
    .irq_ctx_i(irq), .vec_fetch_i(vec), .cache_hit_i(hit), .cache_rdata_i(cache_rd),
    .mem_rdata_i(mem_rd), .ready_o(ready), .rdata_o(rdata), .cond_br_pf_i(cbr),
    .br_in_exec_i(bexec), .pf_hold_o(pf_hold), .wr_evt_i(wr_evt), .erase_evt_i(er_evt),
    .cache_lookup_o(lookup), .cache_use_o(use_c), .cache_invalidate_o(inval),
    .perf_cnt_o(perf), .bus_prio_o(bus_prio)
  );

  function automatic int exp_ws(logic [2:0] m);
    if (m == 3'd0 || m == 3'd2) return 0;
    if (m == 3'd1 || m == 3'd3) return 1;
    return 2;
  endfunction
  function automatic bit exp_supp(logic [2:0] m);
    return (m == 3'd2) || (m == 3'd3) || (m >= 3'd5);
  endfunction
  function automatic bit exp_lookup(logic [31:0] c, logic [1:0] r, bit f);
    if (!f) return 0;
    case (r)
      2'd0: return !c[3];
      2'd1: return !c[6];
      2'd2: return c[7];
      default: return 0;
    endcase
  endfunction
  function automatic bit exp_use(logic [31:0] c, logic [1:0] r, bit f, bit ir, bit vf);
    return exp_lookup(c, r, f) && !(c[5] && (ir || vf));
  endfunction
  function automatic logic [31:0] visible(logic [31:0] w);
    return w & 32'h0003_00FF;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [31:0] w);
    @(negedge clk); cfg_we = 1; cfg_wdata = w;
    @(negedge clk); cfg_we = 0; #1;
    cur_cfg = visible(w);
  endtask

  task automatic access(input logic [1:0] r, input bit f, input bit ir, input bit vf, input bit h);
    int low;
    bit eu;
    int ew;
    logic [DW-1:0] ed;
    @(negedge clk);
    region = r; fetch = f; irq = ir; vec = vf; hit = h;
    mem_rd = $urandom; cache_rd = $urandom; req = 1; #1;
    eu = exp_use(cur_cfg, r, f, ir, vf);
    ew = (eu && h) ? 0 : exp_ws(cur_cfg[2:0]);
    ed = (eu && h) ? cache_rd : mem_rd;
    chk(lookup == exp_lookup(cur_cfg, r, f), "R6 lookup", 32'(lookup), 32'(exp_lookup(cur_cfg, r, f)));
    chk(use_c == eu, "R7 use", 32'(use_c), 32'(eu));
    low = 0;
    while (!ready && low < 8) begin
      chk(rdata == '0, "R3 data zero while stalled", rdata, 0);
      low++; @(negedge clk); #1;
    end
    chk(low == ew, (eu && h) ? "R4 hit wait" : "R3 wait count", low, ew);
    chk(rdata == ed, (eu && h) ? "R4 hit data" : "R3 array data", rdata, ed);
    chk(perf == eu, "R4 perf count", 32'(perf), 32'(eu));
    @(negedge clk); req = 0; hit = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #35 rst_n = 1;
    @(negedge clk); #1;
    chk(cfg_rdata == 32'h1, "R1 reset word", cfg_rdata, 32'h1);
    chk(ready == 0 && inval == 0 && pf_hold == 0, "R1 idle outputs", {ready, inval, pf_hold}, 0);
    chk(bus_prio == 0, "R10 reset prio", 32'(bus_prio), 0);
    access(2'd3, 1, 0, 0, 0); // R1: one wait after reset

    // R9 reserved bits, R10 priority
    wr_cfg(32'hFFFF_FFFF);
    chk(cfg_rdata == 32'h0003_00FF, "R9 reserved zero", cfg_rdata, 32'h0003_00FF);
    chk(bus_prio == 2'd3, "R10 prio", 32'(bus_prio), 3);
    // R8 blocked by auto-invalidate disable
    @(negedge clk); wr_evt = 1; @(negedge clk); wr_evt = 0; #1;
    chk(inval == 0, "R8 inval blocked", 32'(inval), 0);

    // R2 modes 6/7 give two waits; R5 suppression
    for (int m = 0; m < 8; m++) begin
      wr_cfg(32'(m) | 32'h0002_0000);
      chk(bus_prio == 2'd2, "R10 prio follow", 32'(bus_prio), 2);
      access(2'd3, 0, 0, 0, 0); // R2
      cbr = 1; bexec = 0; #1;
      chk(pf_hold == exp_supp(3'(m)), "R5 hold", 32'(pf_hold), 32'(exp_supp(3'(m))));
      bexec = 1; #1;
      chk(pf_hold == 0, "R5 release at execute", 32'(pf_hold), 0);
      cbr = 0; bexec = 0;
    end

    // R8 invalidate pulse on erase
    wr_cfg(32'h0);
    @(negedge clk); er_evt = 1; #1;
    chk(inval == 0, "R8 not before edge", 32'(inval), 0);
    @(negedge clk); er_evt = 0; #1;
    chk(inval == 1, "R8 pulse", 32'(inval), 1);
    @(negedge clk); #1;
    chk(inval == 0, "R8 single cycle", 32'(inval), 0);

    // R7 interrupt-context bypass: lookup on, hit ignored
    wr_cfg(32'h24); // mode 4, irq disable bit
    access(2'd0, 1, 1, 0, 1);
    access(2'd0, 1, 0, 1, 1);
    access(2'd0, 1, 0, 0, 1); // R4 hit served
    // R6 region enables
    wr_cfg(32'h4C); // flash + ext disabled
    access(2'd0, 1, 0, 0, 1);
    access(2'd1, 1, 0, 0, 1);
    access(2'd2, 1, 0, 0, 1);
    wr_cfg(32'hC1);
    access(2'd2, 1, 0, 0, 1);

    // R11 mode write during a stall
    wr_cfg(32'h4);
    @(negedge clk); region = 3; fetch = 0; mem_rd = 32'hA5A5_0001; req = 1;
    cfg_we = 1; cfg_wdata = 32'h0; #1;
    chk(ready == 0, "R11 cycle1 low", 32'(ready), 0);
    @(negedge clk); cfg_we = 0; #1;
    chk(ready == 0, "R11 cycle2 low", 32'(ready), 0);
    @(negedge clk); #1;
    chk(ready == 1 && rdata == 32'hA5A5_0001, "R11 done after two", {31'd0, ready}, 1);
    @(negedge clk); req = 0; cur_cfg = 32'h0;
    access(2'd3, 0, 0, 0, 0); // R11 new mode applies

    // random mix
    for (int i = 0; i < 60; i++) begin
      wr_cfg($urandom);
      access(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule